// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, clock by clock, when the gate of a synchronous-rectifier switch is driven on and off. Three comparator results describe the sensed drain-source voltage. One says the voltage is below the turn-on threshold, which is the most negative of the three. One says it is below the turn-off threshold. One says it is above the positive reset threshold. Two supply flags and an enable decide whether the block may switch at all. The block is in one of three modes: lockout (supply not yet good, or it has fallen), sleep (enable low), or run.

In run mode a fresh crossing below the turn-on threshold switches the gate on. From then on, the turn-off comparator is masked for a programmed number of cycles, so that ringing after turn-on cannot end the pulse early. After that window the gate drops as soon as the voltage rises above the turn-off threshold. Each turn-off opens a blanking window of fixed length, during which turn-on crossings are ignored. This keeps residual body-diode conduction from producing a second pulse. The window closes early when the voltage swings above the positive reset threshold. Every input is sampled through a two-flop synchroniser. The single output is a registered gate enable.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is asserted and after its release, the gate output is 0. The block starts in lockout and stays there, with the gate at 0, until the supply-on flag goes high.
- R2: Run mode is entered only when the supply-on flag and enable are both high. While in lockout, a supply between the two levels (both supply flags low) keeps the block in lockout and ignores turn-on crossings.
- R3: From any mode, the supply-low flag forces lockout and takes priority over enable. Enable low forces sleep. In both modes the gate goes to 0 within 5 cycles and turn-on crossings are ignored.
- R4: In run mode, when the block is armed, a 0-to-1 transition of the below-turn-on flag switches the gate on at the third rising clock edge after the input changes (two synchroniser flops plus one edge register).
- R5: Once on, the gate stays high for at least `min_on_cycles_i` cycles whatever the turn-off flag does. If the turn-off flag is already low at turn-on, the pulse lasts exactly `min_on_cycles_i` cycles. The range used is 20 to 300.
- R6: After the minimum on time, the gate stays high while the below-turn-off flag is 1, and it drops once that flag is 0.
- R7: Each turn-off starts a blanking window of `BLANK_CYCLES` cycles. A turn-on crossing inside the window does not switch the gate on.
- R8: While blanking, the above-reset flag ends the window at once and arms the block. A later turn-on crossing is then accepted even before `BLANK_CYCLES` have passed.
- R9: When the blanking window expires, the block is armed, but a turn-on level held high across the expiry does not switch the gate on. A new 0-to-1 crossing is required.
- R10: Entering run mode from sleep or lockout arms the block, so the first crossing after entry switches the gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_on_i | input | 1 | Supply above the turn-on level |
| supply_low_i | input | 1 | Supply below the lockout level |
| enable_i | input | 1 | Enable; low selects sleep |
| vds_below_on_i | input | 1 | Drain-source voltage below the turn-on threshold |
| vds_below_off_i | input | 1 | Drain-source voltage below the turn-off threshold |
| vds_above_reset_i | input | 1 | Drain-source voltage above the positive reset threshold |
| min_on_cycles_i | input | MINON_W | Minimum on time in clock cycles |
| gate_o | output | 1 | Registered gate enable |

## Verification
The bench builds the block with `BLANK_CYCLES` set to 40 instead of 1500 and keeps the 9-bit minimum-on width. With this setting, the expiry of the blanking window and the held-level case around it fall within a few dozen cycles. The minimum on time is driven at 20 and at 300, the two ends of the intended range. With the 300 setting the masked window is long compared with the blanking window, and the turn-off flag toggles on every cycle of that pulse.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [1:0] {
    MODE_LOCK  = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_RUN   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PH_ARMED   = 2'd0,
    PH_CONDUCT = 2'd1,
    PH_BLANK   = 2'd2
  } phase_e;

  // bit positions inside the synchronised input bundle
  localparam int unsigned IN_SUP_ON  = 0;
  localparam int unsigned IN_SUP_LOW = 1;
  localparam int unsigned IN_EN      = 2;
  localparam int unsigned IN_BON     = 3;
  localparam int unsigned IN_BOFF    = 4;
  localparam int unsigned IN_ARST    = 5;
  localparam int unsigned IN_W       = 6;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sr_mode_fsm.sv
module sr_mode_fsm
  import sr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sup_on_i,
  input  logic sup_low_i,
  input  logic en_i,
  output logic run_o
);

  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (sup_low_i) begin
      mode_d = MODE_LOCK;
    end else begin
      unique case (mode_q)
        MODE_LOCK:  if (sup_on_i) mode_d = en_i ? MODE_RUN : MODE_SLEEP;
        MODE_SLEEP: if (en_i)     mode_d = MODE_RUN;
        MODE_RUN:   if (!en_i)    mode_d = MODE_SLEEP;
        default:                  mode_d = MODE_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_LOCK;
    else        mode_q <= mode_d;
  end

  assign run_o = (mode_q == MODE_RUN);

endmodule

// File: rtl/sr_span_timer.sv
module sr_span_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic         running;

  assign done_o  = (cnt_q != '0) && (cnt_q >= limit_i);
  assign running = (cnt_q != '0) && !done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (start_i)  cnt_q <= W'(1);
    else if (running)  cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/sr_gate_core.sv
module sr_gate_core
  import sr_seq_pkg::*;
#(
  parameter int unsigned MINON_W      = 9,
  parameter int unsigned BLANK_CYCLES = 1500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               below_on_i,
  input  logic               below_off_i,
  input  logic               above_reset_i,
  input  logic [MINON_W-1:0] min_on_i,
  output logic               gate_o
);

  localparam int unsigned BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_LIM = BLANK_W'(BLANK_CYCLES);

  phase_e phase_q, phase_d;
  logic   gate_q, gate_d;
  logic   prev_on_q;
  logic   on_rise;
  logic   on_start, blank_start;
  logic   on_done, blank_done;

  assign on_rise = below_on_i && !prev_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_on_q <= 1'b0;
    else        prev_on_q <= below_on_i;
  end

  always_comb begin
    phase_d     = phase_q;
    gate_d      = gate_q;
    on_start    = 1'b0;
    blank_start = 1'b0;
    if (!run_i) begin
      phase_d = PH_ARMED;
      gate_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_ARMED: begin
          if (on_rise) begin
            phase_d  = PH_CONDUCT;
            gate_d   = 1'b1;
            on_start = 1'b1;
          end
        end
        PH_CONDUCT: begin
          if (on_done && !below_off_i) begin
            phase_d     = PH_BLANK;
            gate_d      = 1'b0;
            blank_start = 1'b1;
          end
        end
        PH_BLANK: begin
          if (above_reset_i || blank_done) phase_d = PH_ARMED;
        end
        default: begin
          phase_d = PH_ARMED;
          gate_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ARMED;
      gate_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      gate_q  <= gate_d;
    end
  end

  sr_span_timer #(.W(MINON_W)) u_on_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!run_i),
    .start_i (on_start),
    .limit_i (min_on_i),
    .done_o  (on_done)
  );

  sr_span_timer #(.W(BLANK_W)) u_blank_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!run_i),
    .start_i (blank_start),
    .limit_i (BLANK_LIM),
    .done_o  (blank_done)
  );

  assign gate_o = gate_q;

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned MINON_W      = 9,
  parameter int unsigned BLANK_CYCLES = 1500,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_on_i,
  input  logic               supply_low_i,
  input  logic               enable_i,
  input  logic               vds_below_on_i,
  input  logic               vds_below_off_i,
  input  logic               vds_above_reset_i,
  input  logic [MINON_W-1:0] min_on_cycles_i,
  output logic               gate_o
);

  logic [IN_W-1:0] raw_in, syn_in;
  logic            run_q;

  always_comb begin
    raw_in             = '0;
    raw_in[IN_SUP_ON]  = supply_on_i;
    raw_in[IN_SUP_LOW] = supply_low_i;
    raw_in[IN_EN]      = enable_i;
    raw_in[IN_BON]     = vds_below_on_i;
    raw_in[IN_BOFF]    = vds_below_off_i;
    raw_in[IN_ARST]    = vds_above_reset_i;
  end

  sr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  sr_mode_fsm u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_on_i  (syn_in[IN_SUP_ON]),
    .sup_low_i (syn_in[IN_SUP_LOW]),
    .en_i      (syn_in[IN_EN]),
    .run_o     (run_q)
  );

  sr_gate_core #(
    .MINON_W      (MINON_W),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_q),
    .below_on_i    (syn_in[IN_BON]),
    .below_off_i   (syn_in[IN_BOFF]),
    .above_reset_i (syn_in[IN_ARST]),
    .min_on_i      (min_on_cycles_i),
    .gate_o        (gate_o)
  );

endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk #(
  parameter int unsigned MINON_W      = 9,
  parameter int unsigned BLANK_CYCLES = 1500
) (
  input logic               clk,
  input logic               rst_n,
  input logic               supply_low_i,
  input logic               enable_i,
  input logic               above_reset_i,
  input logic [MINON_W-1:0] min_on_i,
  input logic               run_i,
  input logic               gate_o
);

  localparam int unsigned LO_W = $clog2(BLANK_CYCLES + 1) + 1;
  localparam logic [LO_W-1:0] LO_LIM = LO_W'(BLANK_CYCLES);

  logic [MINON_W:0] hi_cnt;
  logic [LO_W-1:0]  lo_cnt;
  logic             gate_d;
  logic             open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      gate_d <= 1'b0;
      open_q <= 1'b1;
    end else begin
      gate_d <= gate_o;
      if (!gate_o)          hi_cnt <= '0;
      else if (~&hi_cnt)    hi_cnt <= hi_cnt + 1'b1;
      if (gate_o)           lo_cnt <= '0;
      else if (lo_cnt < LO_LIM) lo_cnt <= lo_cnt + 1'b1;
      if (!run_i || above_reset_i) open_q <= 1'b1;
      else if (gate_d && !gate_o)  open_q <= 1'b0;
    end
  end

  // R3: supply below lockout level for five samples leaves the gate off
  p_lock_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low_i && $past(supply_low_i) && $past(supply_low_i, 2) &&
     $past(supply_low_i, 3) && $past(supply_low_i, 4)) |-> !gate_o);

  // R3: enable low for five samples leaves the gate off
  p_sleep_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !$past(enable_i) && !$past(enable_i, 2) &&
     !$past(enable_i, 3) && !$past(enable_i, 4)) |-> !gate_o);

  // R2: a gate turn-on happens only while the mode logic reports run
  p_rise_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(run_i));

  // R5: a pulse ended by the comparator lasted at least the minimum on time
  p_min_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && $past(run_i)) |-> (hi_cnt >= {1'b0, min_on_i}));

  // R7: a new pulse starts only after a full blanking window unless cut short
  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (open_q || lo_cnt >= LO_LIM));

endmodule

bind sr_gate_seq sr_gate_seq_chk #(
  .MINON_W      (MINON_W),
  .BLANK_CYCLES (BLANK_CYCLES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_low_i  (supply_low_i),
  .enable_i      (enable_i),
  .above_reset_i (vds_above_reset_i),
  .min_on_i      (min_on_cycles_i),
  .run_i         (run_q),
  .gate_o        (gate_o)
);

// File: tb/sr_gate_seq_test.sv
`timescale 1ns/1ps
module sr_gate_seq_test;

  localparam int unsigned BLANK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic son = 1'b0, slow = 1'b1, en = 1'b1;
  logic bon = 1'b0, boff = 1'b0, arst = 1'b0;
  logic [8:0] min_on = 9'd20;
  logic gate;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sr_gate_seq #(.MINON_W(9), .BLANK_CYCLES(BLANK)) uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .supply_on_i       (son),
    .supply_low_i      (slow),
    .enable_i          (en),
    .vds_below_on_i    (bon),
    .vds_below_off_i   (boff),
    .vds_above_reset_i (arst),
    .min_on_cycles_i   (min_on),
    .gate_o            (gate)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       son, slow, en, bon, boff, arst;
    logic [7:0] wait_n;
    logic       exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd5, 1'b0},  // R1 lockout after reset
    '{4'd1, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd8, 1'b0},  // R1 no supply-on yet
    '{4'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd4, 1'b0},  // R2
    '{4'd2, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd6, 1'b0},  // R2 enter run
    '{4'd4, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd5, 1'b1},  // R4 turn-on
    '{4'd6, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd40,1'b1},  // R6 held by turn-off flag
    '{4'd6, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd5, 1'b0},  // R6 turn-off
    '{4'd8, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 8'd5, 1'b0},  // R8 reset threshold
    '{4'd8, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd3, 1'b0},  // R8
    '{4'd8, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd5, 1'b1},  // R8 early re-arm
    '{4'd3, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 8'd6, 1'b0},  // R3 sleep
    '{4'd3, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd3, 1'b0},  // R3
    '{4'd3, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 8'd6, 1'b0},  // R3 crossing in sleep
    '{4'd10,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd6, 1'b0},  // R10 back to run
    '{4'd10,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd5, 1'b1},  // R10 armed on entry
    '{4'd3, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 8'd6, 1'b0},  // R3 lockout over enable
    '{4'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd4, 1'b0},  // R2 between levels
    '{4'd2, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd6, 1'b0},  // R2 crossing ignored
    '{4'd2, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd6, 1'b0},  // R2 run again
    '{4'd10,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'd5, 1'b1},  // R10
    '{4'd6, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd30,1'b0},  // R6
    '{4'd3, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd6, 1'b0}   // R3 lockout from run
  };

  task automatic check(input logic act, input logic exp, input int req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int lo, input int hi, input int req, input string what);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic cut_blank();
    arst = 1'b1;
    repeat (4) @(negedge clk);
    arst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input bit ring, output int w);
    int t = 0;
    while (gate !== 1'b1 && t < 20) begin
      @(negedge clk);
      t++;
    end
    w = 0;
    while (gate === 1'b1 && w < 1000) begin
      w++;
      if (ring) boff = ~boff;
      @(negedge clk);
    end
  endtask

  initial begin
    int w;
    bit hit;
    // R1: reset holds the gate low even with a crossing present
    bon = 1'b1; son = 1'b1; slow = 1'b0;
    repeat (4) @(negedge clk);
    check(gate, 1'b0, 1, "gate during reset");
    bon = 1'b0; son = 1'b0; slow = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      son  = VEC[i].son;  slow = VEC[i].slow; en = VEC[i].en;
      bon  = VEC[i].bon;  boff = VEC[i].boff; arst = VEC[i].arst;
      repeat (VEC[i].wait_n) @(posedge clk);
      @(negedge clk);
      check(gate, VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // back to run mode
    son = 1'b1; slow = 1'b0; en = 1'b1; bon = 1'b0; boff = 1'b0;
    repeat (8) @(negedge clk);

    // R5: exact pulse width at the low end of the range
    min_on = 9'd20;
    cut_blank();
    bon = 1'b1;
    measure(1'b0, w);
    check_int(w, 20, 20, 5, "pulse width min 20");

    // R7: crossing inside blanking ignored
    bon = 1'b0;
    repeat (5) @(negedge clk);
    bon = 1'b1;
    hit = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (gate === 1'b1) hit = 1'b1;
    end
    check(hit, 1'b0, 7, "crossing during blanking");

    // R9: level held across expiry does not turn on; a fresh crossing does
    repeat (60) @(negedge clk);
    check(gate, 1'b0, 9, "held level after expiry");
    bon = 1'b0;
    repeat (3) @(negedge clk);
    bon = 1'b1;
    repeat (5) @(negedge clk);
    check(gate, 1'b1, 9, "fresh crossing after expiry");
    repeat (30) @(negedge clk);
    check(gate, 1'b0, 6, "pulse ended after min on");

    // R8: reset threshold inside blanking re-arms early
    bon = 1'b0;
    repeat (4) @(negedge clk);
    arst = 1'b1;
    repeat (3) @(negedge clk);
    arst = 1'b0;
    repeat (3) @(negedge clk);
    bon = 1'b1;
    repeat (5) @(negedge clk);
    check(gate, 1'b1, 8, "crossing after reset threshold");
    repeat (30) @(negedge clk);

    // R5: upper end with ringing on the turn-off flag
    bon = 1'b0;
    cut_blank();
    min_on = 9'd300;
    bon = 1'b1;
    measure(1'b1, w);
    check_int(w, 300, 301, 5, "pulse width min 300 with ringing");

    // R6: gate held by the turn-off flag past minimum, then released
    bon = 1'b0; boff = 1'b1; min_on = 9'd20;
    cut_blank();
    bon = 1'b1;
    repeat (100) @(negedge clk);
    check(gate, 1'b1, 6, "held past min on");
    boff = 1'b0;
    repeat (4) @(negedge clk);
    check(gate, 1'b0, 6, "released by turn-off flag");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule